// File: doc/BRIEF.md
# Serial Frame Bit Transmitter

The block sends one byte on a single output line as an asynchronous serial frame. Each bit lasts a fixed number of clock cycles, set by a parameter. A normal frame has three parts: one low start bit, then the data bits with the least significant bit first, then a run of high stop bits. The number of stop bits is supplied with every byte. This lets a controller stretch the last byte of a packet with extra stop bits without needing any other logic.

A mark-only mode drops the start bit and the data. It holds the line high for as many bit periods as a normal frame with the same stop count would take, which makes it a packet preamble. With one stop bit that is ten bit periods. The line is driven low whenever no frame is in progress. A one-cycle done pulse marks the end of every frame. A separate controller sequences the bytes of a packet and computes any checksum.

With the default of 63 cycles per bit and a 1.2 MHz clock, the rate is about 19047 baud. A bit period of 62.5 cycles cannot be built, so 19200 baud cannot be reached exactly.

Top module: `sft_frame_tx`

## Requirements
- R1: After reset, and until the first start strobe is accepted, `line_o` and `done_o` are low.
- R2: In normal mode (`mark_only_i`=0), an accepted strobe drives `line_o` low for exactly CYC_PER_BIT cycles, starting in the cycle after the accepting edge.
- R3: After the start bit, the DATA_W data bits follow with bit 0 first. Each bit appears at its true polarity and lasts exactly CYC_PER_BIT cycles.
- R4: After the data bits, `line_o` is high for S bit periods. S is the sampled `stop_cnt_i`, and a sampled value of 0 is treated as S=1.
- R5: In mark-only mode (`mark_only_i`=1), `line_o` is high for (1+DATA_W+S)*CYC_PER_BIT cycles and is never low while the frame runs.
- R6: `done_o` is high for exactly one cycle: the cycle right after the final stop bit period. In that cycle `line_o` is already low.
- R7: A start strobe that arrives while a frame is in progress is ignored. The frame on the line is unchanged.
- R8: `data_i`, `stop_cnt_i` and `mark_only_i` are sampled only at the accepting edge. Changes while the frame runs have no effect on the line.
- R9: Whenever no frame is in progress, `line_o` is low.
- R10: A strobe given in the cycle where `done_o` is high is accepted, and its frame starts right after with no idle bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| data_i | input | DATA_W | Byte to send |
| stop_cnt_i | input | STOP_W | Number of stop bit periods (0 means 1) |
| mark_only_i | input | 1 | 1 = send only high bit periods (preamble) |
| line_o | output | 1 | Serial line |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with CYC_PER_BIT=5, DATA_W=8 and STOP_W=4. The short bit period keeps every frame, including the longest one with 15 stop bits, within a few hundred cycles. As a result, dozens of random frames, the stop count edge values 0, 1 and 15, mark-only preambles and chained frames can all be checked cycle by cycle. Some frames also toggle the start strobe and every data input on each cycle while the frame runs. This shows that only the values sampled at the accepting edge reach the line.

// File: rtl/sft_pkg.sv
package sft_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sft_state_e;
endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
    parameter int CYC_PER_BIT = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic bit_end_o
);
    localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_BIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    // Cycle counter inside one bit period; restarts at every bit boundary
    always_comb begin
        nxt_d = cur_q;
        if (!run_i) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == LAST) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bit_end_o = run_i && (cur_q.cnt == LAST);
endmodule

// File: rtl/sft_frame_ctrl.sv
module sft_frame_ctrl
    import sft_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STOP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [STOP_W-1:0] stop_i,
    input  logic              mark_i,
    input  logic              bit_end_i,
    output logic              line_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              mark_o
);
    localparam int MAX_BITS = 1 + DATA_W + (2 ** STOP_W - 1);
    localparam int IW       = $clog2(MAX_BITS + 1);

    typedef struct packed {
        sft_state_e        state;
        logic [DATA_W-1:0] sh;
        logic [IW-1:0]     idx;
        logic [IW-1:0]     last;
        logic              mark;
        logic              line;
        logic              done;
    } frm_t;

    frm_t cur_q, nxt_d;
    logic [STOP_W-1:0] eff_stop;

    assign eff_stop = (stop_i == '0) ? STOP_W'(1) : stop_i;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.state = ST_RUN;
                    nxt_d.sh    = data_i;
                    nxt_d.mark  = mark_i;
                    nxt_d.idx   = '0;
                    nxt_d.last  = IW'(DATA_W) + IW'(eff_stop);
                    // start bit is low, except in mark-only mode
                    nxt_d.line  = mark_i;
                end
            end
            ST_RUN: begin
                if (bit_end_i) begin
                    if (cur_q.idx == cur_q.last) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.line  = 1'b0;
                        nxt_d.done  = 1'b1;
                    end else begin
                        nxt_d.idx = cur_q.idx + IW'(1);
                        if (nxt_d.idx <= IW'(DATA_W)) begin
                            nxt_d.line = cur_q.mark | cur_q.sh[0];
                            nxt_d.sh   = cur_q.sh >> 1;
                        end else begin
                            nxt_d.line = 1'b1;
                        end
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign line_o = cur_q.line;
    assign done_o = cur_q.done;
    assign busy_o = (cur_q.state == ST_RUN);
    assign mark_o = cur_q.mark;
endmodule

// File: rtl/sft_frame_tx.sv
module sft_frame_tx #(
    parameter int CYC_PER_BIT = 63,
    parameter int DATA_W      = 8,
    parameter int STOP_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [STOP_W-1:0] stop_cnt_i,
    input  logic              mark_only_i,
    output logic              line_o,
    output logic              done_o
);
    logic busy;
    logic bit_end;
    logic mark_q;

    sft_bit_timer #(
        .CYC_PER_BIT(CYC_PER_BIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (busy),
        .bit_end_o(bit_end)
    );

    sft_frame_ctrl #(
        .DATA_W(DATA_W),
        .STOP_W(STOP_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .data_i   (data_i),
        .stop_i   (stop_cnt_i),
        .mark_i   (mark_only_i),
        .bit_end_i(bit_end),
        .line_o   (line_o),
        .done_o   (done_o),
        .busy_o   (busy),
        .mark_o   (mark_q)
    );
endmodule

// File: rtl/sft_frame_tx_chk.sv
module sft_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic line,
    input logic done,
    input logic busy,
    input logic bit_end,
    input logic mark
);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !line);

    // R6
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line);

    // R5
    mark_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mark) |-> line);

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_end) |=> $stable(line));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_end) |=> busy);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !mark) |-> !line);
endmodule

bind sft_frame_tx sft_frame_tx_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .line   (line_o),
    .done   (done_o),
    .busy   (busy),
    .bit_end(bit_end),
    .mark   (mark_q)
);

// File: tb/test_sft_frame_tx.sv
module test_sft_frame_tx;
    localparam int CYC = 5;
    localparam int DW  = 8;
    localparam int SW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [SW-1:0] stop_cnt_i = '0;
    logic          mark_only_i = 1'b0;
    logic          line_o;
    logic          done_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    sft_frame_tx #(
        .CYC_PER_BIT(CYC),
        .DATA_W     (DW),
        .STOP_W     (SW)
    ) i_sft_frame_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .data_i     (data_i),
        .stop_cnt_i (stop_cnt_i),
        .mark_only_i(mark_only_i),
        .line_o     (line_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_stops(input logic [SW-1:0] s);
        return (s == '0) ? 1 : int'(s);
    endfunction

    // expected line level for bit k of a frame
    function automatic logic exp_bit(input int k, input logic [DW-1:0] d, input logic m);
        if (k == 0) return m;
        if (k <= DW) return m | d[k-1];
        return 1'b1;
    endfunction

    function automatic string bit_req(input int k, input logic m);
        if (m) return "R5";
        if (k == 0) return "R2";
        if (k <= DW) return "R3";
        return "R4";
    endfunction

    // Called at the negedge where start_i=1 was driven for this frame.
    task automatic frame_body(input logic [DW-1:0] d, input logic [SW-1:0] s, input logic m,
                              input bit noise, input bit chain,
                              input logic [DW-1:0] nd, input logic [SW-1:0] ns, input logic nm);
        int nb = 1 + DW + eff_stops(s);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < nb; k++) begin
            bit   ok  = 1'b1;
            logic got = exp_bit(k, d, m);
            for (int c = 0; c < CYC; c++) begin
                if (!(k == 0 && c == 0)) @(negedge clk);
                if (line_o !== exp_bit(k, d, m)) begin
                    ok  = 1'b0;
                    got = line_o;
                end
                if (noise) begin
                    // R7 R8: strobes and input changes during the frame
                    start_i     = 1'($urandom);
                    data_i      = DW'($urandom);
                    stop_cnt_i  = SW'($urandom);
                    mark_only_i = 1'($urandom);
                end
            end
            chk(ok, noise ? {bit_req(k, m), "/R8"} : bit_req(k, m), int'(got), int'(exp_bit(k, d, m)));
        end
        @(negedge clk);
        start_i = 1'b0;
        // R6: done pulse and low line right after the last stop bit
        chk(done_o === 1'b1 && line_o === 1'b0, "R6", int'({done_o, line_o}), 2);
        if (chain) begin
            // R10: start in the done cycle
            start_i     = 1'b1;
            data_i      = nd;
            stop_cnt_i  = ns;
            mark_only_i = nm;
        end else begin
            @(negedge clk);
            chk(done_o === 1'b0, "R6", int'(done_o), 0);
            chk(line_o === 1'b0, "R9", int'(line_o), 0);
        end
    endtask

    task automatic send(input logic [DW-1:0] d, input logic [SW-1:0] s, input logic m,
                        input bit noise);
        @(negedge clk);
        start_i     = 1'b1;
        data_i      = d;
        stop_cnt_i  = s;
        mark_only_i = m;
        frame_body(d, s, m, noise, 1'b0, '0, '0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(line_o === 1'b0 && done_o === 1'b0, "R1", int'({done_o, line_o}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(line_o === 1'b0 && done_o === 1'b0, "R1", int'({done_o, line_o}), 0);

        // directed corners
        send(8'h55, 4'd1, 1'b0, 1'b0);  // R2 R3 R4
        send(8'h00, 4'd0, 1'b0, 1'b0);  // R4: zero means one stop bit
        send(8'hFF, 4'd15, 1'b0, 1'b0); // R4: longest stop run
        send(8'hEB, 4'd5, 1'b0, 1'b0);  // R4: extended stop run
        send(8'h00, 4'd1, 1'b1, 1'b0);  // R5: ten-period preamble
        send(8'hA3, 4'd0, 1'b1, 1'b0);  // R5 with zero stop count
        send(8'h3C, 4'd2, 1'b0, 1'b1);  // R7 R8 with noise

        // R10: chained frames
        @(negedge clk);
        start_i = 1'b1; data_i = 8'h10; stop_cnt_i = 4'd1; mark_only_i = 1'b0;
        frame_body(8'h10, 4'd1, 1'b0, 1'b0, 1'b1, 8'hF3, 4'd4, 1'b0);
        frame_body(8'hF3, 4'd4, 1'b0, 1'b0, 1'b1, 8'h00, 4'd1, 1'b1);
        frame_body(8'h00, 4'd1, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0);

        // R9: idle stays low
        begin
            bit ok = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (line_o !== 1'b0) ok = 1'b0;
            end
            chk(ok, "R9", int'(line_o), 0);
        end

        // constrained random frames
        for (int n = 0; n < 40; n++) begin
            logic [DW-1:0] d = DW'($urandom);
            logic [SW-1:0] s = SW'($urandom);
            logic          m = (($urandom % 4) == 0);
            bit            z = (($urandom % 3) == 0);
            send(d, s, m, z);
            repeat ($urandom % 3) @(negedge clk);
        end

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule